// File: doc/BRIEF.md
# Direct I/O Command Slave

This block sits inside a peripheral controller and answers single-word commands that an I/O processor issues over a shared bus. The processor places a device number, a 3-bit command code and (for control and write) a data word on the bus, then raises a service-out strobe. When the device number equals the controller's configured identity and the code names one of the four supported commands, the block carries out the command. It answers with service-in and holds it until the processor drops service-out, which completes a four-phase handshake.

A test command returns the status register. A read command returns a word from the peripheral. A write command stores the bus word in a holding register. Every controller honours two control bits on test and control commands. Bit 0 clears the whole subsystem, and bit 1 clears the pending-interrupt flag. The returned word is driven onto the shared data lines only while the block is acknowledging a test or read. At all other times the lines are released, which is shown by a low output-enable.

Top module: `dio_slave`

## Requirements
- R1: A command whose `bus_devno` differs from `dev_id` is never acknowledged: `svc_in` and `bus_rdata_oe` stay low.
- R2: When the block is idle and samples `svc_out` high with a matching device number and a valid code, `svc_in` is high from the next clock cycle. Valid codes are test=3'b001, control=3'b010, read=3'b011 and write=3'b100.
- R3: `svc_in` stays high while `svc_out` stays high. It goes low in the cycle after `svc_out` is sampled low, and no new command is taken until then.
- R4: Codes 3'b000, 3'b101, 3'b110 and 3'b111 are ignored: there is no `svc_in` and no change to `wr_hold` or `irq_pending`.
- R5: A test command returns the status register as it stood when the command was accepted. The value is on `bus_rdata` with `bus_rdata_oe` high during the acknowledge.
- R6: A read command returns `periph_rdata`, sampled at acceptance, on `bus_rdata` with `bus_rdata_oe` high during the acknowledge.
- R7: A write command loads `bus_wdata` into `wr_hold` and pulses `wr_strobe` for one cycle, in the first acknowledge cycle.
- R8: `bus_rdata_oe` is high only while `svc_in` is high for a test or read, and `bus_rdata` is zero whenever it is low.
- R9: A test or control command with `bus_wdata[0]` set clears the status register, `wr_hold` and `irq_pending` at the accepting edge. It also pulses `master_clr` for one cycle, in the first acknowledge cycle.
- R10: A test or control command with `bus_wdata[1]` set clears `irq_pending` at the accepting edge and leaves `wr_hold` unchanged.
- R11: `irq_req` sampled high sets `irq_pending`. `stat_we` loads `stat_d` into the status register.
- R12: During and right after reset, `svc_in`, `bus_rdata_oe`, `irq_pending`, `wr_hold`, `wr_strobe` and `master_clr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_id | input | 8 | Device number this controller answers to |
| bus_devno | input | 8 | Device number on the bus |
| bus_cmd | input | 3 | Command code on the bus |
| svc_out | input | 1 | Service-out strobe from the I/O processor |
| bus_wdata | input | 16 | Word sent by the processor |
| bus_rdata | output | 16 | Word returned to the processor |
| bus_rdata_oe | output | 1 | Drive enable for the shared data lines |
| svc_in | output | 1 | Service-in acknowledge |
| stat_we | input | 1 | Status register load strobe from the peripheral |
| stat_d | input | 16 | Status value to load |
| periph_rdata | input | 16 | Word returned by a read command |
| irq_req | input | 1 | Interrupt request from the peripheral |
| irq_pending | output | 1 | Pending-interrupt flag |
| wr_hold | output | 16 | Write holding register |
| wr_strobe | output | 1 | One-cycle pulse when a write lands |
| master_clr | output | 1 | One-cycle subsystem master clear pulse |

## Verification
The bench targets a test that also carries the clear bit. A design that cleared the status before latching it would return zero instead of the old status. Unused codes and mismatched device numbers are sent while an interrupt is pending and a word is held. A design with loose decoding would acknowledge them or disturb that state. The bench holds `svc_out` high for several cycles after the acknowledge and watches for `svc_in` to fall too early or too late, and it checks that no second command is accepted under the same strobe. It also checks that a write or control acknowledge never drives the data lines.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int CMD_W = 3;

  localparam logic [CMD_W-1:0] CODE_TEST  = 3'b001;
  localparam logic [CMD_W-1:0] CODE_CTRL  = 3'b010;
  localparam logic [CMD_W-1:0] CODE_READ  = 3'b011;
  localparam logic [CMD_W-1:0] CODE_WRITE = 3'b100;

  typedef struct packed {
    logic test;
    logic ctrl;
    logic read;
    logic write;
  } dio_op_t;

  function automatic dio_op_t op_decode(input logic [CMD_W-1:0] code);
    dio_op_t o;
    o.test  = (code == CODE_TEST);
    o.ctrl  = (code == CODE_CTRL);
    o.read  = (code == CODE_READ);
    o.write = (code == CODE_WRITE);
    return o;
  endfunction

  function automatic logic op_valid(input dio_op_t o);
    return o.test | o.ctrl | o.read | o.write;
  endfunction

  function automatic logic op_returns(input dio_op_t o);
    return o.test | o.read;
  endfunction
endpackage

// File: rtl/dio_decode.sv
module dio_decode
  import dio_pkg::*;
#(
  parameter int DEV_W = 8
) (
  input  logic [DEV_W-1:0] dev_id,
  input  logic [DEV_W-1:0] bus_devno,
  input  logic [CMD_W-1:0] bus_cmd,
  input  logic             svc_out,
  input  logic             idle,
  output logic             accept,
  output dio_op_t          op
);
  logic addr_hit;

  always_comb begin
    addr_hit = (bus_devno == dev_id);
    op       = op_decode(bus_cmd);
    accept   = idle & svc_out & addr_hit & op_valid(op);
  end
endmodule

// File: rtl/dio_handshake.sv
module dio_handshake
  import dio_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    svc_out,
  input  logic    accept,
  input  dio_op_t op,
  output logic    idle,
  output logic    svc_in,
  output logic    ret_sel
);
  typedef enum logic {HS_IDLE, HS_ACK} hs_state_e;
  hs_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      ret_sel <= 1'b0;
    end else begin
      case (state_q)
        HS_IDLE: if (accept) begin
          state_q <= HS_ACK;
          ret_sel <= op_returns(op);
        end
        HS_ACK: if (!svc_out) begin
          state_q <= HS_IDLE;
          ret_sel <= 1'b0;
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  assign idle   = (state_q == HS_IDLE);
  assign svc_in = (state_q == HS_ACK);

  p_accept_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> svc_in);
  p_sin_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_in && svc_out) |=> svc_in);
  p_sin_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_in && !svc_out) |=> !svc_in);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_in && !accept) |=> !svc_in);
endmodule

// File: rtl/dio_regs.sv
module dio_regs
  import dio_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  dio_op_t       op,
  input  logic [DW-1:0] wdata,
  input  logic          stat_we,
  input  logic [DW-1:0] stat_d,
  input  logic [DW-1:0] periph_rdata,
  input  logic          irq_req,
  output logic [DW-1:0] ret_q,
  output logic [DW-1:0] hold_q,
  output logic          irq_pending,
  output logic          wr_strobe,
  output logic          master_clr
);
  localparam int MCLR_BIT  = 0;
  localparam int IRQRST_BIT = 1;

  logic [DW-1:0] status_q;
  logic          ctl_cmd;
  logic          mclr_evt;
  logic          irqrst_evt;
  logic          write_evt;

  always_comb begin
    ctl_cmd    = accept & (op.test | op.ctrl);
    mclr_evt   = ctl_cmd & wdata[MCLR_BIT];
    irqrst_evt = ctl_cmd & wdata[IRQRST_BIT];
    write_evt  = accept & op.write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q    <= '0;
      hold_q      <= '0;
      irq_pending <= 1'b0;
      ret_q       <= '0;
      wr_strobe   <= 1'b0;
      master_clr  <= 1'b0;
    end else begin
      wr_strobe  <= write_evt;
      master_clr <= mclr_evt;

      if (mclr_evt)     status_q <= '0;
      else if (stat_we) status_q <= stat_d;

      if (mclr_evt)       hold_q <= '0;
      else if (write_evt) hold_q <= wdata;

      if (mclr_evt || irqrst_evt) irq_pending <= 1'b0;
      else if (irq_req)           irq_pending <= 1'b1;

      if (accept) begin
        if (op.test)      ret_q <= status_q;
        else if (op.read) ret_q <= periph_rdata;
        else              ret_q <= '0;
      end
    end
  end

  p_mclr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_evt |=> (status_q == '0 && hold_q == '0 && !irq_pending && master_clr));
  p_irq_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irqrst_evt |=> (!irq_pending && $stable(hold_q)));
  p_wr_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    write_evt |=> (hold_q == $past(wdata) && wr_strobe));
  p_irq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !mclr_evt && !irqrst_evt) |=> irq_pending);
endmodule

// File: rtl/dio_slave.sv
module dio_slave
  import dio_pkg::*;
#(
  parameter int DEV_W = 8,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEV_W-1:0] dev_id,
  input  logic [DEV_W-1:0] bus_devno,
  input  logic [CMD_W-1:0] bus_cmd,
  input  logic             svc_out,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_rdata_oe,
  output logic             svc_in,
  input  logic             stat_we,
  input  logic [DW-1:0]    stat_d,
  input  logic [DW-1:0]    periph_rdata,
  input  logic             irq_req,
  output logic             irq_pending,
  output logic [DW-1:0]    wr_hold,
  output logic             wr_strobe,
  output logic             master_clr
);
  logic          idle;
  logic          accept;
  logic          ret_sel;
  dio_op_t       op;
  logic [DW-1:0] ret_q;

  dio_decode #(.DEV_W(DEV_W)) u_decode (
    .dev_id    (dev_id),
    .bus_devno (bus_devno),
    .bus_cmd   (bus_cmd),
    .svc_out   (svc_out),
    .idle      (idle),
    .accept    (accept),
    .op        (op)
  );

  dio_handshake u_hs (
    .clk     (clk),
    .rst_n   (rst_n),
    .svc_out (svc_out),
    .accept  (accept),
    .op      (op),
    .idle    (idle),
    .svc_in  (svc_in),
    .ret_sel (ret_sel)
  );

  dio_regs #(.DW(DW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .op           (op),
    .wdata        (bus_wdata),
    .stat_we      (stat_we),
    .stat_d       (stat_d),
    .periph_rdata (periph_rdata),
    .irq_req      (irq_req),
    .ret_q        (ret_q),
    .hold_q       (wr_hold),
    .irq_pending  (irq_pending),
    .wr_strobe    (wr_strobe),
    .master_clr   (master_clr)
  );

  assign bus_rdata_oe = svc_in & ret_sel;
  assign bus_rdata    = bus_rdata_oe ? ret_q : '0;

  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> svc_in);
  p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata_oe |-> (bus_rdata == '0));
  p_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_out && !svc_in && !op_valid(op_decode(bus_cmd))) |=> !svc_in);
endmodule

// File: tb/dio_slave_tb_top.sv
module dio_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  dev_id = 8'h2C;
  logic [7:0]  bus_devno = 8'h00;
  logic [2:0]  bus_cmd = 3'b000;
  logic        svc_out = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        bus_rdata_oe;
  logic        svc_in;
  logic        stat_we = 1'b0;
  logic [15:0] stat_d = 16'h0;
  logic [15:0] periph_rdata = 16'h0;
  logic        irq_req = 1'b0;
  logic        irq_pending;
  logic [15:0] wr_hold;
  logic        wr_strobe;
  logic        master_clr;

  always #4 clk = ~clk;

  dio_slave dut_i (.*);

  typedef struct {
    logic [15:0] d;
    logic        oe;
    logic        ws;
    logic        mc;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  int n_vec = 0;
  int n_bad = 0;
  logic prev_sin = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop an expected item on each acknowledge rise
  always @(negedge clk) begin
    if (rst_n && svc_in && !prev_sin) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R1 unexpected svc_in", 16'h1, 16'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(bus_rdata == e.d, {e.tag, " data"}, bus_rdata, e.d);
        chk(bus_rdata_oe == e.oe, "R8 oe", {15'h0, bus_rdata_oe}, {15'h0, e.oe});
        chk(wr_strobe == e.ws, "R7 wr_strobe", {15'h0, wr_strobe}, {15'h0, e.ws});
        chk(master_clr == e.mc, "R9 master_clr", {15'h0, master_clr}, {15'h0, e.mc});
      end
    end
    prev_sin <= svc_in;
  end

  task automatic issue(input logic [7:0] dn, input logic [2:0] cmd, input logic [15:0] wd,
                       input bit respond, input logic [15:0] ed, input bit eoe,
                       input bit ews, input bit emc, input string tag);
    exp_t e;
    @(negedge clk);
    bus_devno = dn; bus_cmd = cmd; bus_wdata = wd;
    if (respond) begin
      e.d = ed; e.oe = eoe; e.ws = ews; e.mc = emc; e.tag = tag;
      sb_q.push_back(e);
    end
    svc_out = 1'b1;
    @(negedge clk);
    if (respond) begin
      chk(svc_in == 1'b1, "R2 svc_in one cycle after strobe", {15'h0, svc_in}, 16'h1);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(svc_in == 1'b1, "R3 svc_in held", {15'h0, svc_in}, 16'h1);
      end
      chk(sb_q.size() == 0, "R3 single acceptance", sb_q.size(), 16'h0);
      svc_out = 1'b0;
      @(negedge clk);
      chk(svc_in == 1'b0, "R3 svc_in drop", {15'h0, svc_in}, 16'h0);
      chk(bus_rdata_oe == 1'b0, "R8 oe released", {15'h0, bus_rdata_oe}, 16'h0);
    end else begin
      for (int i = 0; i < 4; i++) begin
        chk(svc_in == 1'b0, {tag, " no svc_in"}, {15'h0, svc_in}, 16'h0);
        chk(bus_rdata_oe == 1'b0, {tag, " no oe"}, {15'h0, bus_rdata_oe}, 16'h0);
        @(negedge clk);
      end
      svc_out = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(svc_in == 0 && bus_rdata_oe == 0 && irq_pending == 0 && wr_hold == 0 &&
        wr_strobe == 0 && master_clr == 0, "R12 in reset", {svc_in, bus_rdata_oe, 14'h0}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(svc_in == 0 && irq_pending == 0 && wr_hold == 0, "R12 after reset",
        wr_hold, 16'h0);

    // load status, then test command (R5, R11)
    stat_we = 1'b1; stat_d = 16'hA5C3;
    @(negedge clk);
    stat_we = 1'b0;
    issue(8'h2C, 3'b001, 16'h0000, 1, 16'hA5C3, 1, 0, 0, "R5 test status");

    // read (R6)
    periph_rdata = 16'h1234;
    issue(8'h2C, 3'b011, 16'h0000, 1, 16'h1234, 1, 0, 0, "R6 read");
    periph_rdata = 16'h0;

    // write (R7, R8)
    issue(8'h2C, 3'b100, 16'hBEEF, 1, 16'h0000, 0, 1, 0, "R7 write");
    chk(wr_hold == 16'hBEEF, "R7 hold value", wr_hold, 16'hBEEF);

    // interrupt request (R11)
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    chk(irq_pending == 1'b1, "R11 irq set", {15'h0, irq_pending}, 16'h1);

    // wrong device number (R1)
    issue(8'h2D, 3'b001, 16'h0003, 0, 16'h0, 0, 0, 0, "R1 mismatch");
    chk(irq_pending == 1'b1 && wr_hold == 16'hBEEF, "R1 state kept", wr_hold, 16'hBEEF);

    // unused codes (R4)
    for (int c = 5; c < 9; c++) begin
      issue(8'h2C, 3'(c), 16'h0003, 0, 16'h0, 0, 0, 0, "R4 unused");
      chk(irq_pending == 1'b1, "R4 irq kept", {15'h0, irq_pending}, 16'h1);
      chk(wr_hold == 16'hBEEF, "R4 hold kept", wr_hold, 16'hBEEF);
    end

    // control bit1: interrupt reset only (R10)
    issue(8'h2C, 3'b010, 16'h0002, 1, 16'h0000, 0, 0, 0, "R10 ctrl");
    chk(irq_pending == 1'b0, "R10 irq cleared", {15'h0, irq_pending}, 16'h0);
    chk(wr_hold == 16'hBEEF, "R10 hold kept", wr_hold, 16'hBEEF);

    // test with clear bit returns old status (R9, R5)
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    issue(8'h2C, 3'b001, 16'h0001, 1, 16'hA5C3, 1, 0, 1, "R9 test+clear");
    chk(wr_hold == 16'h0 && irq_pending == 1'b0, "R9 cleared", wr_hold, 16'h0);
    issue(8'h2C, 3'b001, 16'h0000, 1, 16'h0000, 1, 0, 0, "R9 status zero");

    // control with clear bit after a new write (R9)
    issue(8'h2C, 3'b100, 16'h5A5A, 1, 16'h0000, 0, 1, 0, "R7 write2");
    chk(wr_hold == 16'h5A5A, "R7 hold value2", wr_hold, 16'h5A5A);
    issue(8'h2C, 3'b010, 16'h0001, 1, 16'h0000, 0, 0, 1, "R9 ctrl clear");
    chk(wr_hold == 16'h0, "R9 hold cleared", wr_hold, 16'h0);

    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule